// File: doc/BRIEF.md
# Scatter/Gather List Walker

This block steps through a scatter/gather list that tells a data mover where a command's data lives in host memory. When a command starts, its first two list entries come in with the command's request block. These two entries are held in resident registers and never change for the life of the command. Any further entries are held in one table buffer of four entries. The walker refills that buffer from host memory in 64-byte batches, through a read port that makes one request and then receives sixteen data words.

The data mover sees the current entry's 64-bit address, byte count and flags whenever the entry-valid output is high. It pulses `advance` to consume the entry, or `rescan` to restart the walk from the first resident entry when data arrives out of order. A link entry is not handed to the data mover. The walker follows it by fetching the next table. A link address that is not 8-byte aligned stops the walk with an alignment error.

Top module: `sg_walker`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `entValid`, `listDone`, `alignErr` and `rdReq` are all low.
- R2: A `start` pulse captures both resident entries. From the next cycle the walker presents resident entry 0. An entry is 128 bits of four words: bits 31:0 hold the low address word, bits 63:32 the high address word, bits 95:64 the byte count and bits 127:96 the flags word. In the flags word, bit 31 is last (`entFlags[3]`), bit 30 is link (`entFlags[2]`), bit 29 (`entFlags[1]`) and bit 28 (`entFlags[0]`) are passed through unchanged, and bits 27:0 are ignored.
- R3: With `entValid` high, an `advance` pulse moves to the next entry in order: resident 0, resident 1, then table slots 0 to 3 after a fetch. With no `advance`, `rescan` or `start`, the presented entry stays unchanged.
- R4: An `advance` on an entry whose last flag is set ends the walk. `listDone` goes high and `entValid` goes low. Further `advance` pulses leave both unchanged.
- R5: When the walk reaches a link entry whose address is aligned, the walker raises `rdReq` for exactly one cycle, with `rdReqAddr` equal to that address. It raises it once for each link it reaches.
- R6: From a request until the sixteenth `rdDataValid` word, `entValid` stays low. The words fill the table in arrival order, four words per slot, slot 0 first. The walker then presents table slot 0.
- R7: A link entry whose address bits 2:0 are not all zero raises `alignErr` and issues no read request.
- R8: A `rescan` presents resident entry 0 in the next cycle without any host read. This applies while an entry is valid, after `listDone`, or after `alignErr`. It also clears `listDone` and `alignErr`.
- R9: After a rescan from inside a table, walking forward again issues a fresh fetch from the link address. The walker then presents the newly fetched words, never the buffer contents from before the rescan.
- R10: An `advance` on resident entry 1, or on table slot 3, whose entry is neither last nor link ends the walk with `listDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new command walk; captures the resident entries |
| resEntry0 | input | 128 | First resident entry from the request block |
| resEntry1 | input | 128 | Second resident entry from the request block |
| advance | input | 1 | Consume the current entry |
| rescan | input | 1 | Restart the walk from resident entry 0 |
| rdReq | output | 1 | One-cycle request for a 64-byte table |
| rdReqAddr | output | 64 | Host address of the requested table |
| rdDataValid | input | 1 | A table data word is present |
| rdData | input | 32 | Table data word |
| entValid | output | 1 | Current entry is a data entry ready for use |
| entAddr | output | 64 | Current entry data address |
| entCount | output | 32 | Current entry byte count |
| entFlags | output | 4 | Current entry flags {last, link, pass1, pass0} |
| listDone | output | 1 | Walk finished |
| alignErr | output | 1 | Walk stopped on a misaligned link address |

## Verification
A wrong entry pointer shows at the next settled cycle as an address or count that does not match the expected entry for that step. A stale or mis-filled table shows on the first entry presented after the sixteenth word. A wrong word counter shows either as `entValid` rising before the fetch is complete or as words landing in the wrong slot. A fault in the end-of-walk logic shows as `listDone` arriving one entry early or late, or as a walk that does not stop when the data mover keeps pulsing `advance`.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 2 * WORD_W;
  localparam int CNT_W      = WORD_W;
  localparam int WPE        = 4;                  // words per entry
  localparam int ENT_W      = WPE * WORD_W;
  localparam int RES_N      = 2;
  localparam int TBL_N      = 4;
  localparam int TBL_WORDS  = TBL_N * WPE;
  localparam int WIDX_W     = $clog2(TBL_WORDS);
  localparam int SLOT_N     = RES_N + TBL_N;
  localparam int SEL_W      = $clog2(SLOT_N);
  localparam int ALIGN_BITS = 3;

  typedef struct packed {
    logic trm;
    logic lnk;
    logic pass1;
    logic pass0;
  } flags_t;

  typedef struct packed {
    flags_t              flags;
    logic [CNT_W-1:0]    count;
    logic [ADDR_W-1:0]   addr;
  } entry_t;

  typedef struct packed {
    logic              loadRes;
    logic              tblWr;
    logic [WIDX_W-1:0] wordIdx;
    logic [SEL_W-1:0]  sel;
  } strobes_t;

  function automatic entry_t decodeEntry(input logic [ENT_W-1:0] raw);
    entry_t e;
    e.addr  = raw[2*WORD_W-1:0];
    e.count = raw[3*WORD_W-1:2*WORD_W];
    e.flags = raw[ENT_W-1 -: 4];
    return e;
  endfunction
endpackage

// File: rtl/sgw_store.sv
module sgw_store
  import sgw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [ENT_W-1:0]    res0Raw,
  input  logic [ENT_W-1:0]    res1Raw,
  input  logic [WORD_W-1:0]   rdData,
  output entry_t              cur
);
  localparam int RIDX_W = $clog2(RES_N);
  localparam int TSEL_W = $clog2(TBL_N);

  logic [ENT_W-1:0]  resMem [RES_N];
  logic [WORD_W-1:0] tblMem [TBL_WORDS];
  logic [ENT_W-1:0]  curRaw;
  logic [TSEL_W-1:0] tblSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RES_N; i++) resMem[i] <= '0;
    end else if (stb.loadRes) begin
      resMem[0] <= res0Raw;
      resMem[1] <= res1Raw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_WORDS; i++) tblMem[i] <= '0;
    end else if (stb.tblWr) begin
      tblMem[stb.wordIdx] <= rdData;
    end
  end

  always_comb begin
    tblSlot = TSEL_W'(stb.sel - SEL_W'(RES_N));
    curRaw  = '0;
    if (stb.sel < SEL_W'(RES_N)) begin
      curRaw = resMem[stb.sel[RIDX_W-1:0]];
    end else begin
      for (int w = 0; w < WPE; w++)
        curRaw[w*WORD_W +: WORD_W] = tblMem[{tblSlot, 2'(w)}];
    end
    cur = decodeEntry(curRaw);
  end
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              advance,
  input  logic              rescan,
  input  logic              rdDataValid,
  input  entry_t            cur,
  output strobes_t          stb,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdReqAddr,
  output logic              entValid,
  output logic              listDone,
  output logic              alignErr
);
  typedef enum logic [2:0] {S_IDLE, S_WALK, S_FETCH, S_DONE, S_ERR} state_t;

  state_t            state;
  logic [SEL_W-1:0]  ptr;
  logic [WIDX_W-1:0] wordCnt;
  logic              onLink, misaligned, lastSlot;

  always_comb begin
    onLink      = (state == S_WALK) && cur.flags.lnk;
    misaligned  = |cur.addr[ALIGN_BITS-1:0];
    lastSlot    = (ptr == SEL_W'(RES_N - 1)) || (ptr == SEL_W'(SLOT_N - 1));
    rdReq       = onLink && !misaligned;
    rdReqAddr   = cur.addr;
    entValid    = (state == S_WALK) && !cur.flags.lnk;
    listDone    = (state == S_DONE);
    alignErr    = (state == S_ERR);
    stb.loadRes = start;
    stb.tblWr   = (state == S_FETCH) && rdDataValid;
    stb.wordIdx = wordCnt;
    stb.sel     = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      ptr     <= '0;
      wordCnt <= '0;
    end else if (start) begin
      state   <= S_WALK;
      ptr     <= '0;
      wordCnt <= '0;
    end else begin
      unique case (state)
        S_WALK: begin
          if (onLink) begin
            wordCnt <= '0;
            state   <= misaligned ? S_ERR : S_FETCH;
          end else if (rescan) begin
            ptr <= '0;
          end else if (advance) begin
            if (cur.flags.trm || lastSlot) state <= S_DONE;
            else                           ptr   <= ptr + SEL_W'(1);
          end
        end
        S_FETCH: begin
          if (rdDataValid) begin
            wordCnt <= wordCnt + WIDX_W'(1);
            if (wordCnt == WIDX_W'(TBL_WORDS - 1)) begin
              state <= S_WALK;
              ptr   <= SEL_W'(RES_N);
            end
          end
        end
        S_DONE, S_ERR: begin
          if (rescan) begin
            state <= S_WALK;
            ptr   <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ENT_W-1:0]  resEntry0,
  input  logic [ENT_W-1:0]  resEntry1,
  input  logic              advance,
  input  logic              rescan,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdReqAddr,
  input  logic              rdDataValid,
  input  logic [WORD_W-1:0] rdData,
  output logic              entValid,
  output logic [ADDR_W-1:0] entAddr,
  output logic [CNT_W-1:0]  entCount,
  output logic [3:0]        entFlags,
  output logic              listDone,
  output logic              alignErr
);
  strobes_t stb;
  entry_t   cur;

  sgw_ctrl u_ctrl (
    .clk, .rstN, .start, .advance, .rescan, .rdDataValid,
    .cur, .stb, .rdReq, .rdReqAddr, .entValid, .listDone, .alignErr
  );

  sgw_store u_store (
    .clk, .rstN, .stb, .res0Raw(resEntry0), .res1Raw(resEntry1),
    .rdData, .cur
  );

  assign entAddr  = cur.addr;
  assign entCount = cur.count;
  assign entFlags = cur.flags;
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker
  import sgw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              advance,
  input logic              rescan,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdReqAddr,
  input logic              rdDataValid,
  input logic              entValid,
  input logic [ADDR_W-1:0] entAddr,
  input logic [CNT_W-1:0]  entCount,
  input logic              listDone,
  input logic              alignErr
);
  logic              inFetch;
  logic [WIDX_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFetch <= 1'b0;
      seen    <= '0;
    end else if (rdReq) begin
      inFetch <= 1'b1;
      seen    <= '0;
    end else if (inFetch && rdDataValid) begin
      seen <= seen + WIDX_W'(1);
      if (seen == WIDX_W'(TBL_WORDS - 1)) inFetch <= 1'b0;
    end
  end

  AST_REQ_PULSE:    assert property (@(posedge clk) disable iff (!rstN) rdReq |=> !rdReq);                        // R5
  AST_REQ_ALIGNED:  assert property (@(posedge clk) disable iff (!rstN) rdReq |-> rdReqAddr[ALIGN_BITS-1:0] == '0); // R7
  AST_FETCH_QUIET:  assert property (@(posedge clk) disable iff (!rstN) inFetch |-> !entValid);                    // R6
  AST_DONE_EXCL:    assert property (@(posedge clk) disable iff (!rstN) listDone |-> !entValid && !rdReq);         // R4
  AST_DONE_STICKY:  assert property (@(posedge clk) disable iff (!rstN) listDone && !start && !rescan |=> listDone); // R4
  AST_ERR_NOREQ:    assert property (@(posedge clk) disable iff (!rstN) alignErr |-> !rdReq && !entValid);         // R7
  AST_ENTRY_HOLD:   assert property (@(posedge clk) disable iff (!rstN)
                      entValid && !advance && !rescan && !start |=> entValid && $stable(entAddr) && $stable(entCount)); // R3
endmodule

bind sg_walker sgw_checker u_sgw_checker (
  .clk, .rstN, .start, .advance, .rescan, .rdReq, .rdReqAddr, .rdDataValid,
  .entValid, .entAddr, .entCount, .listDone, .alignErr
);

// File: tb/sg_walker_bench.sv
module sg_walker_bench;
  import sgw_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN, start, advance, rescan, rdDataValid;
  logic [ENT_W-1:0]  resEntry0, resEntry1;
  logic [WORD_W-1:0] rdData;
  logic              rdReq, entValid, listDone, alignErr;
  logic [ADDR_W-1:0] rdReqAddr, entAddr;
  logic [CNT_W-1:0]  entCount;
  logic [3:0]        entFlags;

  sg_walker u_sg_walker (
    .clk, .rstN, .start, .resEntry0, .resEntry1, .advance, .rescan,
    .rdReq, .rdReqAddr, .rdDataValid, .rdData,
    .entValid, .entAddr, .entCount, .entFlags, .listDone, .alignErr
  );

  int total = 0, bad = 0, reqCnt = 0;
  logic [63:0]  tblAddr [4];
  logic [31:0]  tblW    [4][16];
  logic [127:0] resRaw  [2];
  logic [127:0] expSeq  [64];
  int expLen, expReq;
  bit expErr;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mkEnt(logic [63:0] a, logic [31:0] c, logic [3:0] f);
    return {f, 28'($urandom), c, a};
  endfunction

  function automatic logic [99:0] visible(logic [127:0] e);
    return {e[127:124], e[95:64], e[63:0]};
  endfunction

  function automatic logic [99:0] outNow();
    return {entFlags, entCount, entAddr};
  endfunction

  function automatic logic [127:0] getEnt(int r, int i);
    if (r < 0) return resRaw[i];
    return {tblW[r][i*4+3], tblW[r][i*4+2], tblW[r][i*4+1], tblW[r][i*4]};
  endfunction

  function automatic int findTbl(logic [63:0] a);
    for (int t = 0; t < 4; t++) if (tblAddr[t] == a) return t;
    return -1;
  endfunction

  // slot generator: region r (-1 = resident) may link only to region r+1
  function automatic logic [127:0] genSlot(int r);
    int x;
    logic [63:0] a;
    x = int'($urandom % 10);
    if (x < 3 && r < 3) begin
      a = tblAddr[r+1];
      if ($urandom % 8 == 0) a[2:0] = 3'($urandom % 7 + 1);
      return mkEnt(a, $urandom, {2'b01, 2'($urandom)});
    end
    return mkEnt({$urandom, $urandom}, $urandom, {x == 3, 1'b0, 2'($urandom)});
  endfunction

  task automatic genList();
    for (int t = 0; t < 4; t++) tblAddr[t] = {$urandom, ($urandom & 32'hFFFF_F000) | (t << 8)};
    resRaw[0] = genSlot(-1);
    resRaw[1] = genSlot(-1);
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 4; s++) begin
        logic [127:0] e;
        e = genSlot(t);
        for (int w = 0; w < 4; w++) tblW[t][s*4+w] = e[w*32 +: 32];
      end
  endtask

  // reference walk over the requirements
  task automatic refWalk();
    int r, i;
    logic [127:0] e;
    r = -1; i = 0; expLen = 0; expReq = 0; expErr = 0;
    for (int g = 0; g < 40; g++) begin
      e = getEnt(r, i);
      if (e[126]) begin
        if (|e[2:0]) begin expErr = 1; break; end
        expReq++;
        r = findTbl(e[63:0]);
        i = 0;
        continue;
      end
      expSeq[expLen] = e;
      expLen++;
      if (e[127]) break;
      if ((r < 0 && i == 1) || (r >= 0 && i == 3)) break;
      i++;
    end
  endtask

  task automatic doStart();
    resEntry0 = resRaw[0]; resEntry1 = resRaw[1];
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic doAdvance();
    advance = 1'b1; @(negedge clk); advance = 1'b0;
  endtask

  task automatic doRescan();
    rescan = 1'b1; @(negedge clk); rescan = 1'b0;
  endtask

  task automatic waitOutcome();
    int guard = 0;
    while (!(entValid || listDone || alignErr) && guard < 400) begin
      @(negedge clk); guard++;
    end
    if (guard >= 400) chk(0, "R6 walk stalled", 0, 1);
  endtask

  // host read responder
  initial begin
    rdDataValid = 1'b0; rdData = '0;
    @(negedge clk);
    forever begin
      if (rdReq) begin
        int t;
        bit quiet = 1;
        reqCnt++;
        t = findTbl(rdReqAddr);
        chk(t >= 0, "R5 request address matches a link", 128'(rdReqAddr), 0);
        if (t < 0) t = 0;
        repeat (1 + $urandom % 3) begin
          @(negedge clk);
          if (entValid) quiet = 0;
        end
        for (int w = 0; w < 16; w++) begin
          if ($urandom % 4 == 0) begin
            if (entValid) quiet = 0;
            @(negedge clk);
          end
          if (entValid) quiet = 0;
          rdDataValid = 1'b1; rdData = tblW[t][w];
          @(negedge clk);
          rdDataValid = 1'b0;
        end
        chk(quiet, "R6 entValid low during fetch", 128'(quiet), 1);
      end else begin
        @(negedge clk);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic runRandom(bit withRescan);
    int n, base, rescanAt;
    bit rescanned;
    genList();
    refWalk();
    base = reqCnt; n = 0; rescanned = 0;
    rescanAt = (expLen > 0) ? 1 + int'($urandom % expLen) : 0;
    doStart();
    for (int g = 0; g < 80; g++) begin
      waitOutcome();
      if (!entValid) break;
      chk(visible(expSeq[n]) == outNow(), n == 0 ? "R2 first entry" : "R3 next entry",
          128'(outNow()), 128'(visible(expSeq[n])));
      n++;
      if (withRescan && !rescanned && n == rescanAt) begin
        rescanned = 1; n = 0;
        doRescan();
      end else begin
        doAdvance();
      end
    end
    if (expErr) chk(alignErr && n == expLen, "R7 misaligned link stops walk", {alignErr, 32'(n)}, {1'b1, 32'(expLen)});
    else        chk(listDone && n == expLen, "R10 walk ends after expected entries", {listDone, 32'(n)}, {1'b1, 32'(expLen)});
    if (!rescanned) chk(reqCnt - base == expReq, "R5 one request per link", reqCnt - base, expReq);
    if (listDone) begin
      doAdvance(); doAdvance();
      chk(listDone && !entValid, "R4 advance ignored after done", {listDone, entValid}, 2'b10);
    end
  endtask

  initial begin
    void'($urandom(32'd4321));
    rstN = 1'b0; start = 0; advance = 0; rescan = 0;
    resEntry0 = '0; resEntry1 = '0;
    repeat (3) @(negedge clk);
    chk(!entValid && !listDone && !alignErr && !rdReq, "R1 reset outputs",
        {entValid, listDone, alignErr, rdReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!entValid && !listDone && !alignErr && !rdReq, "R1 after reset release",
        {entValid, listDone, alignErr, rdReq}, 0);

    // directed: two resident data entries, no last flag -> done after slot 1
    for (int t = 0; t < 4; t++) tblAddr[t] = 64'h0000_0040_0000_1000 + 64'(t * 256);
    resRaw[0] = mkEnt(64'h1111_2222_3333_4440, 32'h100, 4'b0001);
    resRaw[1] = mkEnt(64'h5555_6666_7777_8880, 32'h200, 4'b0010);
    doStart();
    chk(entValid && outNow() == visible(resRaw[0]), "R2 resident 0 presented", 128'(outNow()), 128'(visible(resRaw[0])));
    doAdvance();
    chk(entValid && outNow() == visible(resRaw[1]), "R3 resident 1 presented", 128'(outNow()), 128'(visible(resRaw[1])));
    doAdvance();
    chk(listDone && !entValid, "R10 end of resident region", {listDone, entValid}, 2'b10);
    doRescan();
    chk(entValid && !listDone && outNow() == visible(resRaw[0]), "R8 rescan after done", 128'(outNow()), 128'(visible(resRaw[0])));

    // directed: link to a table, rescan from inside it, refetch new contents
    reqCnt = 0;
    resRaw[1] = mkEnt(tblAddr[0], 0, 4'b0100);
    for (int s = 0; s < 4; s++) begin
      logic [127:0] e;
      e = mkEnt({$urandom, $urandom}, 32'h1000 + 32'(s), {s == 2, 3'b000});
      for (int w = 0; w < 4; w++) tblW[0][s*4+w] = e[w*32 +: 32];
    end
    doStart();
    doAdvance();
    waitOutcome();
    chk(entValid && outNow() == visible(getEnt(0, 0)), "R6 table slot 0 after fetch", 128'(outNow()), 128'(visible(getEnt(0, 0))));
    chk(reqCnt == 1, "R5 single fetch for link", reqCnt, 1);
    doRescan();
    chk(entValid && outNow() == visible(resRaw[0]), "R8 rescan presents resident 0", 128'(outNow()), 128'(visible(resRaw[0])));
    chk(reqCnt == 1, "R8 rescan issues no read", reqCnt, 1);
    tblW[0][2] = 32'hCAFE_0001;
    doAdvance();
    waitOutcome();
    chk(entValid && entCount == 32'hCAFE_0001, "R9 refetched table used", 128'(entCount), 128'(32'hCAFE_0001));
    chk(reqCnt == 2, "R9 second fetch issued", reqCnt, 2);
    doAdvance(); doAdvance(); doAdvance();
    chk(listDone, "R4 last flag ends walk", 128'(listDone), 1);

    // directed: misaligned link in resident 0
    reqCnt = 0;
    resRaw[0] = mkEnt(tblAddr[0] | 64'h4, 0, 4'b0100);
    doStart();
    @(negedge clk);
    chk(alignErr && !entValid, "R7 misaligned link flagged", {alignErr, entValid}, 2'b10);
    repeat (4) @(negedge clk);
    chk(reqCnt == 0, "R7 no read for misaligned link", reqCnt, 0);

    for (int k = 0; k < 60; k++) runRandom(k % 2 == 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule